// File: doc/BRIEF.md
# Time-Slot Interchange Output Controller

This block builds the outgoing side of a time-slot switch. There are eight serial output streams. Each stream carries a frame of 32 byte-wide channels, and each channel is sent most significant bit first, one bit per clock. For every output stream and channel, a per-channel control word picks one of two sources for the outgoing byte:

- **Switched data:** the byte is read from a data memory that holds the received input channels. The address is a source stream and channel taken from a low connection memory.
- **Message byte:** the low connection memory byte itself is sent, repeated every frame.

The per-channel control word also gates the driver of that channel. The outputs are modelled as a data bit and a drive-enable per stream, not as real tri-state pins.

A second serial output carries one control bit per stream and channel. It runs one channel ahead of the data streams, with stream 0 first within each slot. Two global inputs override the per-channel words:

- a drive-enable input that silences every stream;
- a message override that forces every channel into message mode and drives it.

Software-side writes reach three memories through simple write ports: the data memory, the low connection memory and the high connection memory. Frame alignment comes from a one-cycle sync pulse.

Top module: `tsi_out_ctrl`

## Requirements
- R1: With high-connection bit 2 at 0, the byte sent on a stream/channel is the data-memory entry whose address is the low-connection byte for that stream/channel. That byte holds the source stream in bits 7-5 and the source channel in bits 4-0, so the data-memory address is stream*32+channel.
- R2: With high-connection bit 2 at 1, the low-connection byte itself is sent on that channel, and it is sent again in every following frame.
- R3: High-connection bit 0 sets the drive of its stream/channel: 1 raises `sto_oe` for that stream during the channel's 8 bit slots, 0 keeps it low.
- R4: While `ode_i` is low, every bit of `sto_oe` is low in the same cycle.
- R5: While `glb_msg_i` is high, every channel behaves as if high-connection bits 2 and 0 were both 1. Every stream is then driven with its low-connection byte, unless `ode_i` is low.
- R6: After a clock edge with `fsync_i` high, channel 0 bit 7 appears. Each channel then occupies 8 consecutive cycles, bits 7 down to 0, and channels follow in ascending order.
- R7: During bit slot p (0..7) of channel c, `cst_o` carries high-connection bit 1 of stream p, channel c+1 (channel 31 wraps to 0).
- R8: While reset is applied, `sto_oe` is all zero, and `sto_data` and `cst_o` are 0.
- R9: Without a new sync pulse, the frame wraps after 256 cycles and repeats the same channel sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync: the next cycle starts channel 0 |
| ode_i | input | 1 | Global drive enable |
| glb_msg_i | input | 1 | Global message-mode override |
| dm_we_i | input | 1 | Data memory write strobe |
| dm_addr_i | input | 8 | Data memory address, stream*32+channel |
| dm_wdata_i | input | 8 | Data memory write byte |
| cm_we_i | input | 1 | Connection memory write strobe |
| cm_hi_i | input | 1 | 1 selects the high connection memory, 0 the low one |
| cm_addr_i | input | 8 | Connection address, output stream*32+channel |
| cm_wdata_i | input | 8 | Connection write byte; the high memory keeps bits 2..0 |
| sto_data_o | output | 8 | Serial data bit per output stream |
| sto_oe_o | output | 8 | Drive enable per output stream |
| cst_o | output | 1 | Serial control bitstream |

## Verification
The bench builds the block with its defaults: eight streams, 32 channels and 8-bit bytes. This means every stream/channel pair and every data-memory address can be filled with computed patterns and checked over two full frames. The vector table pairs memory patterns with each combination of the drive-enable and message override. This brings within reach the wrap of the control bitstream from channel 31 to 0, the re-alignment by a sync pulse in mid-frame, and the frame repeat without sync. Directed steps cover reset applied both at start and in mid-run.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // per-channel control bits that steer the data path
  typedef struct packed {
    logic msg;  // send the stored byte instead of switched data
    logic oe;   // drive this channel
  } chan_ctl_t;

  localparam int CM_MSG_BIT = 2;
  localparam int CM_CST_BIT = 1;
  localparam int CM_OE_BIT  = 0;
endpackage

// File: rtl/tsi_rst_sync.sv
module tsi_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/tsi_ram.sv
module tsi_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int NRD   = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int NCH = 32,
  parameter int W   = 8,
  localparam int CAW = $clog2(NCH),
  localparam int BW  = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           fsync_i,
  output logic           load_o,
  output logic [CAW-1:0] ch_next_o,
  output logic [CAW-1:0] ch_ahead_o
);
  localparam logic [CAW-1:0] CH_LAST  = CAW'(NCH - 1);
  localparam logic [BW-1:0]  BIT_LAST = BW'(W - 1);

  logic [BW-1:0]  bit_q, bit_d;
  logic [CAW-1:0] ch_q, ch_d, ch_inc;
  logic           slot_end;

  assign slot_end = (bit_q == BIT_LAST);
  assign ch_inc   = (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;

  always_comb begin
    bit_d = bit_q;
    ch_d  = ch_q;
    if (fsync_i) begin
      bit_d = '0;
      ch_d  = '0;
    end else if (slot_end) begin
      bit_d = '0;
      ch_d  = ch_inc;
    end else begin
      bit_d = bit_q + 1'b1;
    end
  end

  // reset parks on the last slot so the first edge fetches channel 0
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= BIT_LAST;
      ch_q  <= CH_LAST;
    end else begin
      bit_q <= bit_d;
      ch_q  <= ch_d;
    end
  end

  assign load_o     = fsync_i | slot_end;
  assign ch_next_o  = fsync_i ? '0 : ch_inc;
  assign ch_ahead_o = (ch_next_o == CH_LAST) ? '0 : ch_next_o + 1'b1;

  // R6
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fsync_i |=> (bit_q == '0 && ch_q == '0));

  // R9
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bit_q == BIT_LAST && ch_q == CH_LAST && !fsync_i) |=> (bit_q == '0 && ch_q == '0));
endmodule

// File: rtl/tsi_lane.sv
module tsi_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         msg_i,
  input  logic         oe_i,
  input  logic [W-1:0] msg_byte_i,
  input  logic [W-1:0] sw_byte_i,
  output logic         ser_o,
  output logic         en_o
);
  logic [W-1:0] sh_q, sh_d;
  logic         en_q, en_d;

  always_comb begin
    sh_d = {sh_q[W-2:0], 1'b0};
    en_d = en_q;
    if (load_i) begin
      sh_d = msg_i ? msg_byte_i : sw_byte_i;
      en_d = oe_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      en_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      en_q <= en_d;
    end
  end

  assign ser_o = sh_q[W-1];
  assign en_o  = en_q;

  // R6
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_i |=> (sh_q == {$past(sh_q[W-2:0]), 1'b0}));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_i |=> $stable(en_q));
endmodule

// File: rtl/tsi_out_ctrl.sv
module tsi_out_ctrl #(
  parameter int NSTR = 8,
  parameter int NCH  = 32,
  parameter int W    = 8,
  localparam int SAW = $clog2(NSTR),
  localparam int CAW = $clog2(NCH),
  localparam int AW  = SAW + CAW
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            fsync_i,
  input  logic            ode_i,
  input  logic            glb_msg_i,
  input  logic            dm_we_i,
  input  logic [AW-1:0]   dm_addr_i,
  input  logic [W-1:0]    dm_wdata_i,
  input  logic            cm_we_i,
  input  logic            cm_hi_i,
  input  logic [AW-1:0]   cm_addr_i,
  input  logic [W-1:0]    cm_wdata_i,
  output logic [NSTR-1:0] sto_data_o,
  output logic [NSTR-1:0] sto_oe_o,
  output logic            cst_o
);
  import tsi_pkg::*;

  localparam int DEPTH = NSTR * NCH;

  logic                      rst_n_s;
  logic                      load;
  logic [CAW-1:0]            ch_next, ch_ahead;
  logic [NSTR-1:0][AW-1:0]   nxt_addr, ahead_addr, dm_addr;
  logic [NSTR-1:0][W-1:0]    cml_rd, dm_rd;
  logic [NSTR-1:0][1:0]      ctl_rd;
  logic [NSTR-1:0][0:0]      cst_rd;
  logic [NSTR-1:0]           lane_en;
  logic [NSTR-1:0]           cst_q, cst_d;
  chan_ctl_t                 ctl_wdata;

  tsi_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_sync_no(rst_n_s));

  tsi_frame_timer #(.NCH(NCH), .W(W)) u_timer (
    .clk(clk), .rst_ni(rst_n_s), .fsync_i(fsync_i),
    .load_o(load), .ch_next_o(ch_next), .ch_ahead_o(ch_ahead)
  );

  assign ctl_wdata.msg = cm_wdata_i[CM_MSG_BIT];
  assign ctl_wdata.oe  = cm_wdata_i[CM_OE_BIT];

  for (genvar s = 0; s < NSTR; s++) begin : g_addr
    assign nxt_addr[s]   = {SAW'(s), ch_next};
    assign ahead_addr[s] = {SAW'(s), ch_ahead};
    assign dm_addr[s]    = cml_rd[s][W-1 -: AW];
  end

  tsi_ram #(.DW(W), .DEPTH(DEPTH), .NRD(NSTR)) u_dmem (
    .clk(clk), .we_i(dm_we_i), .waddr_i(dm_addr_i), .wdata_i(dm_wdata_i),
    .raddr_i(dm_addr), .rdata_o(dm_rd)
  );

  tsi_ram #(.DW(W), .DEPTH(DEPTH), .NRD(NSTR)) u_cml (
    .clk(clk), .we_i(cm_we_i & ~cm_hi_i), .waddr_i(cm_addr_i), .wdata_i(cm_wdata_i),
    .raddr_i(nxt_addr), .rdata_o(cml_rd)
  );

  tsi_ram #(.DW(2), .DEPTH(DEPTH), .NRD(NSTR)) u_cmh_ctl (
    .clk(clk), .we_i(cm_we_i & cm_hi_i), .waddr_i(cm_addr_i), .wdata_i(ctl_wdata),
    .raddr_i(nxt_addr), .rdata_o(ctl_rd)
  );

  tsi_ram #(.DW(1), .DEPTH(DEPTH), .NRD(NSTR)) u_cmh_cst (
    .clk(clk), .we_i(cm_we_i & cm_hi_i), .waddr_i(cm_addr_i),
    .wdata_i(cm_wdata_i[CM_CST_BIT]),
    .raddr_i(ahead_addr), .rdata_o(cst_rd)
  );

  for (genvar s = 0; s < NSTR; s++) begin : g_lane
    chan_ctl_t ctl;
    assign ctl = chan_ctl_t'(ctl_rd[s]);

    tsi_lane #(.W(W)) u_lane (
      .clk(clk), .rst_ni(rst_n_s), .load_i(load),
      .msg_i(glb_msg_i | ctl.msg), .oe_i(glb_msg_i | ctl.oe),
      .msg_byte_i(cml_rd[s]), .sw_byte_i(dm_rd[s]),
      .ser_o(sto_data_o[s]), .en_o(lane_en[s])
    );
  end

  // control bitstream: stream 0 leaves first within each channel slot
  always_comb begin
    cst_d = {1'b0, cst_q[NSTR-1:1]};
    if (load) begin
      for (int s = 0; s < NSTR; s++) cst_d[s] = cst_rd[s][0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cst_q <= '0;
    else          cst_q <= cst_d;
  end

  assign cst_o    = cst_q[0];
  assign sto_oe_o = lane_en & {NSTR{ode_i}};

  // R5
  glb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (load && glb_msg_i) |=> (sto_oe_o == {NSTR{ode_i}}));

  // R8
  always @(posedge clk) begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (sto_oe_o == '0 && cst_o == 1'b0);
    end
  end
endmodule

// File: tb/tsi_out_ctrl_tb.sv
module tsi_out_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 32;
  localparam int FRAME = NC * 8;
  localparam int DEPTH = NS * NC;

  // {global message, global drive enable, pattern seed}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b1, 8'd0},
    {1'b0, 1'b1, 8'd1},
    {1'b1, 1'b1, 8'd2},
    {1'b0, 1'b0, 8'd3},
    {1'b1, 1'b0, 8'd4},
    {1'b0, 1'b1, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_n, fsync, ode, glb;
  logic dm_we, cm_we, cm_hi;
  logic [7:0] dm_addr, dm_wdata, cm_addr, cm_wdata;
  logic [NS-1:0] sto_data, sto_oe;
  logic cst;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] dm_m  [DEPTH];
  logic [7:0] cml_m [DEPTH];
  logic [2:0] cmh_m [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_out_ctrl dut_i (
    .clk(clk), .rst_ni(rst_n), .fsync_i(fsync), .ode_i(ode), .glb_msg_i(glb),
    .dm_we_i(dm_we), .dm_addr_i(dm_addr), .dm_wdata_i(dm_wdata),
    .cm_we_i(cm_we), .cm_hi_i(cm_hi), .cm_addr_i(cm_addr), .cm_wdata_i(cm_wdata),
    .sto_data_o(sto_data), .sto_oe_o(sto_oe), .cst_o(cst)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic load_mem(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      dm_m[i]  = 8'((i * 37 + seed * 11 + 5) & 255);
      cml_m[i] = 8'((i * 73 + seed * 29 + 3) & 255);
      cmh_m[i] = 3'(((i * 5 + seed * 3) ^ (i >> 3)) & 7);
      @(negedge clk);
      dm_we = 1'b1; dm_addr = 8'(i); dm_wdata = dm_m[i];
      cm_we = 1'b1; cm_hi = 1'b0; cm_addr = 8'(i); cm_wdata = cml_m[i];
      @(negedge clk);
      dm_we = 1'b0;
      cm_hi = 1'b1; cm_wdata = {5'b10101, cmh_m[i]};
    end
  endtask

  // sync pulse, then two frames compared against the model (R6 alignment, R9 repeat)
  task automatic run_frames(input logic g, input logic o);
    @(negedge clk);
    dm_we = 1'b0; cm_we = 1'b0; glb = g; ode = o; fsync = 1'b1;
    @(posedge clk);
    for (int j = 0; j < 2 * FRAME; j++) begin
      int jj, ch, b, p, idx;
      logic [7:0] exp_oe, exp_d, byte_v;
      logic exp_cst;
      string sfx;
      @(negedge clk);
      fsync = 1'b0;
      jj = j % FRAME; ch = jj / 8; b = 7 - (jj % 8); p = jj % 8;
      sfx = (j >= FRAME) ? " R9" : " R6";
      for (int s = 0; s < NS; s++) begin
        idx = s * NC + ch;
        byte_v = (g | cmh_m[idx][2]) ? cml_m[idx] : dm_m[cml_m[idx]];
        exp_d[s]  = byte_v[b];
        exp_oe[s] = o & (g | cmh_m[idx][0]);
      end
      exp_cst = cmh_m[p * NC + ((ch + 1) % NC)][1];
      chk($sformatf("%s%s oe slot %0d", !o ? "R4" : (g ? "R5" : "R3"), sfx, j),
          sto_oe, exp_oe);
      chk($sformatf("%s%s data slot %0d", g ? "R5" : "R1,R2", sfx, j),
          sto_data & exp_oe, exp_d & exp_oe);
      chk($sformatf("R7%s ctl slot %0d", sfx, j), {7'd0, cst}, {7'd0, exp_cst});
    end
  endtask

  initial begin
    rst_n = 1'b0; fsync = 1'b0; ode = 1'b1; glb = 1'b1;
    dm_we = 1'b0; cm_we = 1'b0; cm_hi = 1'b0;
    dm_addr = '0; dm_wdata = '0; cm_addr = '0; cm_wdata = '0;
    repeat (3) @(negedge clk);
    // R8 reset state with both global overrides active
    chk("R8 oe in reset", sto_oe, 8'h00);
    chk("R8 data in reset", sto_data, 8'h00);
    chk("R8 ctl in reset", {7'd0, cst}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      load_mem(int'(VEC[v][7:0]));
      // leave the frame running out of phase before re-aligning
      repeat (v * 13 + 5) @(negedge clk);
      run_frames(VEC[v][9], VEC[v][8]);
    end

    // R8 reset applied in mid-run
    @(negedge clk);
    ode = 1'b1; glb = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 oe after mid-run reset", sto_oe, 8'h00);
    chk("R8 ctl after mid-run reset", {7'd0, cst}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule